// File: doc/BRIEF.md
# Integer Execution Unit with Iterative Divider

This block is the integer arithmetic stage of a 32-bit processor pipeline. It receives an operation code and one or two register operands on an issue strobe. It returns the word that is written back to the destination register. Addition, subtraction, multiplication, the bitwise group, the relational group and the barrel shifter all produce their result one clock after the operation is accepted.

Division runs on a restoring shift-subtract engine that handles one quotient bit per cycle. While it runs, the unit raises `busy` and ignores any new issue. When the quotient is written, it pulses `resultValid` and drops `busy` on the same edge.

An operation code outside the defined set is still accepted. It returns zero and raises an unimplemented-operation flag, so the surrounding pipeline can raise its own exception.

Top module: `alu_core`

## Requirements
- R1: After reset, and before any operation is issued, `result` is 0 and `resultValid`, `busy` and `badOp` are 0.
- R2: Code 0x00 returns srcA+srcB and code 0x01 returns srcA-srcB, both modulo 2^32, so they serve signed and unsigned operands alike.
- R3: Codes 0x02 (signed) and 0x03 (unsigned) return the low 32 bits of srcA*srcB, which are the same word for both.
- R4: Code 0x06 returns AND, 0x07 returns OR, 0x08 returns NOR and 0x09 returns XOR of the two operands.
- R5: The relational codes return the word 1 when the condition holds and 0 otherwise: 0x0A equal, 0x0B not equal, 0x0C signed greater-or-equal, 0x0D signed less-than, 0x0E unsigned greater-or-equal, 0x0F unsigned less-than (all as srcA against srcB).
- R6: The shift codes use srcB[4:0] as the amount (0 to 31) and ignore srcB[31:5]: 0x10 logical left, 0x11 logical right, 0x12 arithmetic right, 0x13 rotate left, 0x14 rotate right, all applied to srcA.
- R7: An operation is accepted on a rising edge where `opValid` is 1 and `busy` is 0. For every code other than the two divide codes, `resultValid` is 1 in the cycle after acceptance, and `busy` stays 0.
- R8: Code 0x05 returns the unsigned quotient srcA/srcB, and it returns 0xFFFFFFFF when srcB is 0.
- R9: Code 0x04 returns the signed quotient rounded toward zero. A zero divisor gives 0xFFFFFFFF for a non-negative dividend and 0x00000001 for a negative one. 0x80000000 divided by 0xFFFFFFFF gives 0x80000000.
- R10: After a divide is accepted, `busy` is 1 for 33 cycles. `resultValid` then pulses in the cycle where `busy` returns to 0, which is 34 cycles after acceptance. `opValid` raised while `busy` is 1 is ignored: it produces no result pulse, and the quotient is delivered unchanged.
- R11: Codes 0x15 to 0x1F are undefined. They are accepted like single-cycle operations, pulse `badOp` together with `resultValid`, and return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Issue strobe for an operation |
| opCode | input | 5 | Operation code |
| srcA | input | 32 | First register operand |
| srcB | input | 32 | Second register operand or shift amount |
| result | output | 32 | Write-back word, held until the next result |
| resultValid | output | 1 | One-cycle pulse when `result` is new |
| busy | output | 1 | Divider is running; issues are ignored |
| badOp | output | 1 | Pulses with `resultValid` for an undefined code |

## Verification
Every code is swept across a cross product of extreme operands (0, 1, all ones, the most negative and most positive values, and shift amounts of 31 and 32), and across pseudo-random pairs as well.

The divide corners are checked directly:
- A zero divisor with each dividend sign catches a divider that returns garbage or applies the wrong sign fix-up.
- The most negative value divided by -1 catches a divider that saturates or overflows.
- A shift amount with upper bits set exposes a shifter that uses more than five bits.
- Mixed-sign compares expose signed and unsigned compares that have been swapped.

Issues raised while the divider runs would show up as a spurious result pulse or a corrupted quotient. The exact latency count catches an off-by-one in the iteration counter.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W = 5;

  localparam logic [OP_W-1:0] OP_ADD  = 5'h00;
  localparam logic [OP_W-1:0] OP_SUB  = 5'h01;
  localparam logic [OP_W-1:0] OP_MULS = 5'h02;
  localparam logic [OP_W-1:0] OP_MULU = 5'h03;
  localparam logic [OP_W-1:0] OP_DIVS = 5'h04;
  localparam logic [OP_W-1:0] OP_DIVU = 5'h05;
  localparam logic [OP_W-1:0] OP_AND  = 5'h06;
  localparam logic [OP_W-1:0] OP_OR   = 5'h07;
  localparam logic [OP_W-1:0] OP_NOR  = 5'h08;
  localparam logic [OP_W-1:0] OP_XOR  = 5'h09;
  localparam logic [OP_W-1:0] OP_CEQ  = 5'h0A;
  localparam logic [OP_W-1:0] OP_CNE  = 5'h0B;
  localparam logic [OP_W-1:0] OP_CGES = 5'h0C;
  localparam logic [OP_W-1:0] OP_CLTS = 5'h0D;
  localparam logic [OP_W-1:0] OP_CGEU = 5'h0E;
  localparam logic [OP_W-1:0] OP_CLTU = 5'h0F;
  localparam logic [OP_W-1:0] OP_SLL  = 5'h10;
  localparam logic [OP_W-1:0] OP_SRL  = 5'h11;
  localparam logic [OP_W-1:0] OP_SRA  = 5'h12;
  localparam logic [OP_W-1:0] OP_ROL  = 5'h13;
  localparam logic [OP_W-1:0] OP_ROR  = 5'h14;
  localparam logic [OP_W-1:0] OP_LAST = OP_ROR;

  // strobes from control to datapath
  typedef struct packed {
    logic takeSingle;
    logic takeBad;
    logic divLoad;
    logic divStep;
    logic divFinish;
  } aluStrobe_t;

  function automatic logic isDivOp(input logic [OP_W-1:0] code);
    return (code == OP_DIVS) || (code == OP_DIVU);
  endfunction

  function automatic logic isKnownOp(input logic [OP_W-1:0] code);
    return code <= OP_LAST;
  endfunction

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  output aluStrobe_t      strobe,
  output logic            busy,
  output logic            resultValid,
  output logic            badOp
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_e;

  state_e           state;
  logic [CNT_W-1:0] stepCnt;
  logic             accept;

  assign accept = opValid && (state == S_IDLE);
  assign busy   = (state != S_IDLE);

  always_comb begin
    strobe            = '0;
    strobe.divLoad    = accept && isDivOp(opCode);
    strobe.takeBad    = accept && !isKnownOp(opCode);
    strobe.takeSingle = accept && isKnownOp(opCode) && !isDivOp(opCode);
    strobe.divStep    = (state == S_RUN);
    strobe.divFinish  = (state == S_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      stepCnt     <= '0;
      resultValid <= 1'b0;
      badOp       <= 1'b0;
    end else begin
      resultValid <= strobe.takeSingle || strobe.takeBad || strobe.divFinish;
      badOp       <= strobe.takeBad;
      unique case (state)
        S_IDLE: if (strobe.divLoad) begin
          state   <= S_RUN;
          stepCnt <= '0;
        end
        S_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST_STEP) state <= S_FIN;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobe_t        strobe,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result
);

  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]     shAmt;
  logic [2*DATA_W-1:0] rotL, rotR;
  logic [DATA_W-1:0]   singleRes;

  assign shAmt = srcB[SH_W-1:0];
  assign rotL  = {srcA, srcA} << shAmt;
  assign rotR  = {srcA, srcA} >> shAmt;

  always_comb begin
    singleRes = '0;
    unique case (opCode)
      OP_ADD:            singleRes = srcA + srcB;
      OP_SUB:            singleRes = srcA - srcB;
      OP_MULS, OP_MULU:  singleRes = srcA * srcB;
      OP_AND:            singleRes = srcA & srcB;
      OP_OR:             singleRes = srcA | srcB;
      OP_NOR:            singleRes = ~(srcA | srcB);
      OP_XOR:            singleRes = srcA ^ srcB;
      OP_CEQ:            singleRes = DATA_W'(srcA == srcB);
      OP_CNE:            singleRes = DATA_W'(srcA != srcB);
      OP_CGES:           singleRes = DATA_W'($signed(srcA) >= $signed(srcB));
      OP_CLTS:           singleRes = DATA_W'($signed(srcA) < $signed(srcB));
      OP_CGEU:           singleRes = DATA_W'(srcA >= srcB);
      OP_CLTU:           singleRes = DATA_W'(srcA < srcB);
      OP_SLL:            singleRes = srcA << shAmt;
      OP_SRL:            singleRes = srcA >> shAmt;
      OP_SRA:            singleRes = DATA_W'($signed(srcA) >>> shAmt);
      OP_ROL:            singleRes = rotL[2*DATA_W-1:DATA_W];
      OP_ROR:            singleRes = rotR[DATA_W-1:0];
      default:           singleRes = '0;
    endcase
  end

  // restoring divider on operand magnitudes
  logic              divSigned, negA, negB;
  logic [DATA_W-1:0] magA, magB;
  logic [DATA_W:0]   divRem;
  logic [DATA_W-1:0] divQuo, divDen;
  logic              divNeg;
  logic [DATA_W:0]   remShift;
  logic [DATA_W+1:0] remDiff;

  assign divSigned = (opCode == OP_DIVS);
  assign negA      = divSigned && srcA[DATA_W-1];
  assign negB      = divSigned && srcB[DATA_W-1];
  assign magA      = negA ? (~srcA + 1'b1) : srcA;
  assign magB      = negB ? (~srcB + 1'b1) : srcB;
  assign remShift  = {divRem[DATA_W-1:0], divQuo[DATA_W-1]};
  assign remDiff   = {1'b0, remShift} - {2'b00, divDen};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divRem <= '0;
      divQuo <= '0;
      divDen <= '0;
      divNeg <= 1'b0;
      result <= '0;
    end else begin
      if (strobe.divLoad) begin
        divRem <= '0;
        divQuo <= magA;
        divDen <= magB;
        divNeg <= negA ^ negB;
      end else if (strobe.divStep) begin
        if (remDiff[DATA_W+1]) begin
          divRem <= remShift;
          divQuo <= {divQuo[DATA_W-2:0], 1'b0};
        end else begin
          divRem <= remDiff[DATA_W:0];
          divQuo <= {divQuo[DATA_W-2:0], 1'b1};
        end
      end
      if (strobe.takeSingle)     result <= singleRes;
      else if (strobe.takeBad)   result <= '0;
      else if (strobe.divFinish) result <= divNeg ? (~divQuo + 1'b1) : divQuo;
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              busy,
  output logic              badOp
);

  aluStrobe_t strobe;

  alu_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .strobe(strobe), .busy(busy), .resultValid(resultValid), .badOp(badOp)
  );

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .result(result)
  );

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [OP_W-1:0]   opCode,
  input logic [DATA_W-1:0] result,
  input logic              resultValid,
  input logic              busy,
  input logic              badOp
);

  logic issue, isCmp;
  assign issue = opValid && !busy;
  assign isCmp = (opCode >= OP_CEQ) && (opCode <= OP_CLTU);

  assert_single_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    issue && isKnownOp(opCode) && !isDivOp(opCode) |=> resultValid && !busy && !badOp);

  assert_bad_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    issue && !isKnownOp(opCode) |=> resultValid && badOp && (result == '0));

  assert_cmp_boolean_R5: assert property (@(posedge clk) disable iff (!rstN)
    issue && isCmp |=> (result[DATA_W-1:1] == '0));

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> !busy);

  assert_busy_from_div_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(opValid && isDivOp(opCode)));

  assert_result_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(result) && !resultValid);

  assert_flag_with_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    badOp |-> resultValid);

endmodule

bind alu_core alu_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
  .result(result), .resultValid(resultValid), .busy(busy), .badOp(badOp)
);

// File: tb/tb_alu_core.sv
`timescale 1ns/1ps
module tb_alu_core;

  localparam int W = 32;
  localparam logic [W-1:0] MINV = 32'h8000_0000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opValid = 1'b0;
  logic [4:0]   opCode = '0;
  logic [W-1:0] srcA = '0, srcB = '0;
  logic [W-1:0] result;
  logic         resultValid, busy, badOp;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  alu_core #(.DATA_W(W)) dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .result(result),
    .resultValid(resultValid), .busy(busy), .badOp(badOp)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [4:0] op);
    if (op <= 5'h01) return "R2";
    if (op <= 5'h03) return "R3";
    if (op == 5'h04) return "R9";
    if (op == 5'h05) return "R8";
    if (op <= 5'h09) return "R4";
    if (op <= 5'h0F) return "R5";
    if (op <= 5'h14) return "R6";
    return "R11";
  endfunction

  function automatic logic [W-1:0] model(input logic [4:0] op,
                                         input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] dbl;
    int unsigned s;
    s = int'(b[4:0]);
    dbl = {a, a};
    case (op)
      5'h00: return a + b;
      5'h01: return a - b;
      5'h02, 5'h03: return a * b;
      5'h04: begin
        if (b == 0) return a[W-1] ? 32'h1 : 32'hFFFF_FFFF;
        if (a == MINV && b == 32'hFFFF_FFFF) return MINV;
        return W'($signed(a) / $signed(b));
      end
      5'h05: return (b == 0) ? 32'hFFFF_FFFF : a / b;
      5'h06: return a & b;
      5'h07: return a | b;
      5'h08: return ~(a | b);
      5'h09: return a ^ b;
      5'h0A: return {31'd0, a == b};
      5'h0B: return {31'd0, a != b};
      5'h0C: return {31'd0, $signed(a) >= $signed(b)};
      5'h0D: return {31'd0, $signed(a) < $signed(b)};
      5'h0E: return {31'd0, a >= b};
      5'h0F: return {31'd0, a < b};
      5'h10: return a << s;
      5'h11: return a >> s;
      5'h12: return W'($signed(a) >>> s);
      5'h13: begin dbl = dbl << s; return dbl[2*W-1:W]; end
      5'h14: begin dbl = dbl >> s; return dbl[W-1:0]; end
      default: return '0;
    endcase
  endfunction

  task automatic runOp(input logic [4:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] exp;
    string req;
    int waited;
    exp = model(op, a, b);
    req = reqOf(op);
    @(negedge clk);
    opValid = 1'b1; opCode = op; srcA = a; srcB = b;
    @(negedge clk);
    opValid = 1'b0;
    if (op == 5'h04 || op == 5'h05) begin
      waited = 1;
      while (!resultValid && waited < 60) begin
        if (!busy) check(1'b0, "R10", "busy low before quotient", W'(busy), 1);
        @(negedge clk);
        waited++;
      end
      check(waited == W + 2, "R10", "divide latency", W'(waited), W'(W + 2));
      check(!busy, "R10", "busy at completion", W'(busy), 0);
    end else begin
      check(resultValid && !busy, "R7", "single-cycle valid", W'({busy, resultValid}), 1);
    end
    check(result == exp, req, $sformatf("op %h a=%h b=%h", op, a, b), result, exp);
    check(badOp == (op > 5'h14), req, "unimplemented flag", W'(badOp), W'(op > 5'h14));
  endtask

  logic [W-1:0] corners [10] = '{32'h0, 32'h1, 32'h2, 32'h7FFF_FFFF, MINV,
                                 32'hFFFF_FFFF, 32'h5555_5555, 32'd31, 32'd32, 32'h1234_5678};

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] lfsrA, lfsrB;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(result == 0 && !resultValid && !busy && !badOp, "R1", "reset outputs",
          W'({result != 0, resultValid, busy, badOp}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(result == 0 && !resultValid && !busy && !badOp, "R1", "after release",
          W'({result != 0, resultValid, busy, badOp}), 0);

    // corner sweep over every code including undefined ones (R2..R9, R11)
    for (int op = 0; op < 32; op++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          runOp(5'(op), corners[i], corners[j]);

    // pseudo-random operand pairs
    lfsrA = 32'hACE1_2468; lfsrB = 32'h1357_9BDF;
    for (int k = 0; k < 40; k++) begin
      lfsrA = {lfsrA[30:0], lfsrA[31] ^ lfsrA[21] ^ lfsrA[1] ^ lfsrA[0]};
      lfsrB = {lfsrB[30:0], lfsrB[31] ^ lfsrB[21] ^ lfsrB[1] ^ lfsrB[0]};
      for (int op = 0; op < 21; op++)
        runOp(5'(op), lfsrA, (k % 4 == 0) ? (lfsrB >> 20) : lfsrB);
    end

    // R6: upper shift bits ignored
    runOp(5'h10, 32'h0000_00F1, 32'hFFFF_FFE4);
    runOp(5'h13, 32'h8000_0001, 32'h0000_0021);
    // R9 explicit corners
    runOp(5'h04, MINV, 32'hFFFF_FFFF);
    runOp(5'h04, 32'hFFFF_FFF9, 32'h0);
    runOp(5'h04, 32'h7, 32'h0);
    runOp(5'h04, 32'hFFFF_FFF9, 32'h2);
    // R8 explicit corner
    runOp(5'h05, 32'hDEAD_BEEF, 32'h0);

    // R10: issues while busy are ignored
    begin : busyIgnore
      int pulses;
      int waited;
      pulses = 0;
      waited = 1;
      @(negedge clk);
      opValid = 1'b1; opCode = 5'h05; srcA = 32'd1000; srcB = 32'd7;
      @(negedge clk);
      opCode = 5'h00; srcA = 32'h1; srcB = 32'h1;
      while (!resultValid && waited < 60) begin
        @(negedge clk);
        waited++;
      end
      opValid = 1'b0;
      check(waited == W + 2, "R10", "latency with issues pending", W'(waited), W'(W + 2));
      check(result == 32'd142, "R10", "quotient untouched by ignored issues", result, 32'd142);
      @(negedge clk);
      if (resultValid) pulses++;
      check(pulses <= 1, "R10", "no extra pulses", W'(pulses), 1);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule